// File: doc/BRIEF.md
# Request/Wait Read Link

This block is the responding side of a read-only bus on which a requester raises a request line and the responder either answers inside a fixed access window or stretches the cycle with a wait line. The responder wraps a data source whose ready latency changes from one read to the next. When the latency fits inside the window, it drives the data and leaves wait low. When it does not, it raises wait early in the window, holds wait high until the data is there, and then drives the data while lowering wait.

For testing, a matching requester sits in the same top. It starts a read on `rd_start`, counts cycles from the rise of its request, and samples the bus at the window edge unless wait is high at that moment. If wait is high, it samples in the first cycle in which wait is low again. It then drops the request and reports the captured byte, the number of cycles the read took, and whether the read was stretched.

Cycle numbering used below: cycle 0 is the first cycle in which `bus_req` is high. `TA` is the access window in cycles, and `L` is the ready latency supplied for that read.

Top module: `rqw_link`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `bus_req`, `bus_wait`, `bus_drive` and `rd_done` are low and `bus_data` is 0.
- R2: A `rd_start` sampled high while no read is in progress raises `bus_req` in the following cycle. A `rd_start` sampled during a read is ignored: it does not change the read in progress and does not start a second read after it.
- R3: Fast read (L <= TA): `bus_wait` stays low for the whole read. `bus_drive` is high from cycle max(L,1) through cycle TA, and the requester samples at the end of cycle TA.
- R4: Slow read (L > TA): `bus_wait` is high in cycles 1 through L-1 and never high together with `bus_drive`. In cycle L, `bus_wait` is low and `bus_drive` is high.
- R5: In a slow read, the requester samples at the end of the first cycle in which `bus_wait` is low, which is cycle L.
- R6: In the cycle after the sample (cycle c+1), `bus_req` is low and `rd_done` is high for exactly one cycle. In that cycle `rd_data` holds the byte from the bus, `rd_cycles` equals c, and `rd_stretched` is 1 only for a slow read.
- R7: The responder drives the bus only while `bus_req` is high. When `bus_drive` is low, `bus_data` reads 0.
- R8: `src_lat` and `src_val` (8-bit data) are taken in cycle 0 of a read. Changing them later in the read affects neither the data nor the timing.
- R9: A `rd_start` that is high in the `rd_done` cycle starts the next read at once: `bus_req` is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | Request a read from the requester |
| src_lat | input | LAT_W | Ready latency of the data source for this read, in cycles |
| src_val | input | DATA_W | Byte the data source returns for this read |
| rd_busy | output | 1 | Requester has a read in progress |
| rd_done | output | 1 | One-cycle pulse: the captured read result is valid |
| rd_data | output | DATA_W | Captured byte |
| rd_cycles | output | CNT_W | Cycles from request rise to sample |
| rd_stretched | output | 1 | The read was stretched by wait |
| bus_req | output | 1 | Request line |
| bus_wait | output | 1 | Wait line |
| bus_drive | output | 1 | Responder is driving the data bus |
| bus_data | output | DATA_W | Data bus |

## Verification
The bound checker covers the relations that must hold on every cycle:
- the bus is driven only under a request, and wait is raised only under a request;
- wait and drive are never high together;
- a request that stays high while wait falls is driven in the same cycle;
- wait rises only after the request is already up;
- `rd_done` is a single-cycle pulse that comes with the request low;
- an unstretched read always reports exactly TA cycles.

Only the bench scenarios can show the rest:
- the exact cycle in which wait falls and the data appears for a given latency;
- the value captured;
- that late changes to the source inputs and extra start pulses are ignored;
- that a start in the done cycle chains without a gap.

// File: rtl/rqw_pkg.sv
package rqw_pkg;

  typedef enum logic [1:0] {
    MST_IDLE    = 2'd0,
    MST_WINDOW  = 2'd1,
    MST_STRETCH = 2'd2
  } mst_state_e;

endpackage

// File: rtl/rqw_source.sv
// Data source with a per-read ready latency. A load pulse captures the
// latency and value. Ready is raised once the elapsed count reaches the
// latency. The late flag marks a latency beyond the access window.
module rqw_source #(
  parameter int DATA_W = 8,
  parameter int LAT_W  = 4,
  parameter int TA     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LAT_W-1:0]  lat_in,
  input  logic [DATA_W-1:0] val_in,
  output logic              ready,
  output logic              late,
  output logic [DATA_W-1:0] val
);

  localparam int unsigned TA_U = TA;

  logic [LAT_W-1:0]  lat_q, lat_d;
  logic [LAT_W-1:0]  elap_q, elap_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic              late_q, late_d;
  logic              elap_en;

  assign elap_en = (elap_q < lat_q);

  always_comb begin
    lat_d  = lat_q;
    val_d  = val_q;
    late_d = late_q;
    elap_d = elap_q;
    if (load) begin
      lat_d  = lat_in;
      val_d  = val_in;
      late_d = (32'(lat_in) > TA_U);
      elap_d = LAT_W'(1);
    end else if (elap_en) begin
      elap_d = elap_q + LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      val_q  <= '0;
      late_q <= 1'b0;
      elap_q <= '0;
    end else begin
      lat_q  <= lat_d;
      val_q  <= val_d;
      late_q <= late_d;
      elap_q <= elap_d;
    end
  end

  assign ready = (elap_q >= lat_q);
  assign late  = late_q;
  assign val   = val_q;

endmodule

// File: rtl/rqw_slave.sv
// Responder: starts the source when it sees a new request. It raises wait
// one cycle later when the source is late, and it drives the data while
// the request is held and the source is ready.
module rqw_slave #(
  parameter int DATA_W = 8,
  parameter int LAT_W  = 4,
  parameter int TA     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [LAT_W-1:0]  src_lat,
  input  logic [DATA_W-1:0] src_val,
  output logic              wait_o,
  output logic              drive_o,
  output logic [DATA_W-1:0] data_o
);

  logic              act_q, act_d;
  logic              start;
  logic              ready;
  logic              late;
  logic [DATA_W-1:0] val;

  assign start = req && !act_q;
  assign act_d = req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  rqw_source #(
    .DATA_W (DATA_W),
    .LAT_W  (LAT_W),
    .TA     (TA)
  ) src_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .lat_in (src_lat),
    .val_in (src_val),
    .ready  (ready),
    .late   (late),
    .val    (val)
  );

  assign wait_o  = act_q && req && late && !ready;
  assign drive_o = act_q && req && ready;
  assign data_o  = drive_o ? val : '0;

endmodule

// File: rtl/rqw_master.sv
// Requester: raises req, counts the access window, samples at TA unless
// wait is high, otherwise samples on the first cycle in which wait is low.
module rqw_master #(
  parameter int DATA_W = 8,
  parameter int TA     = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bus_wait,
  input  logic [DATA_W-1:0] bus_data,
  output logic              req,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  cycles,
  output logic              stretched
);

  import rqw_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] TA_CNT  = CNT_W'(TA);

  mst_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cap;
  logic              done_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cyc_q;
  logic              str_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cap   = 1'b0;
    unique case (st_q)
      MST_IDLE: begin
        if (start) begin
          st_d  = MST_WINDOW;
          cnt_d = '0;
        end
      end
      MST_WINDOW: begin
        if (cnt_q == TA_CNT) begin
          if (bus_wait) begin
            st_d = MST_STRETCH;
          end else begin
            cap  = 1'b1;
            st_d = MST_IDLE;
          end
        end
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
      end
      MST_STRETCH: begin
        if (!bus_wait) begin
          cap  = 1'b1;
          st_d = MST_IDLE;
        end
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
      end
      default: st_d = MST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cyc_q  <= '0;
      str_q  <= 1'b0;
    end else if (cap) begin
      data_q <= bus_data;
      cyc_q  <= cnt_q;
      str_q  <= (st_q == MST_STRETCH);
    end
  end

  assign req       = (st_q != MST_IDLE);
  assign busy      = req;
  assign done      = done_q;
  assign data      = data_q;
  assign cycles    = cyc_q;
  assign stretched = str_q;

endmodule

// File: rtl/rqw_link.sv
module rqw_link #(
  parameter int DATA_W = 8,
  parameter int LAT_W  = 4,
  parameter int TA     = 4,
  localparam int LAT_MAX = (1 << LAT_W) - 1,
  localparam int SPAN    = (TA > LAT_MAX) ? TA : LAT_MAX,
  localparam int CNT_W   = $clog2(SPAN + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [LAT_W-1:0]  src_lat,
  input  logic [DATA_W-1:0] src_val,
  output logic              rd_busy,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_cycles,
  output logic              rd_stretched,
  output logic              bus_req,
  output logic              bus_wait,
  output logic              bus_drive,
  output logic [DATA_W-1:0] bus_data
);

  rqw_master #(
    .DATA_W (DATA_W),
    .TA     (TA),
    .CNT_W  (CNT_W)
  ) mst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_start),
    .bus_wait  (bus_wait),
    .bus_data  (bus_data),
    .req       (bus_req),
    .busy      (rd_busy),
    .done      (rd_done),
    .data      (rd_data),
    .cycles    (rd_cycles),
    .stretched (rd_stretched)
  );

  rqw_slave #(
    .DATA_W (DATA_W),
    .LAT_W  (LAT_W),
    .TA     (TA)
  ) slv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (bus_req),
    .src_lat (src_lat),
    .src_val (src_val),
    .wait_o  (bus_wait),
    .drive_o (bus_drive),
    .data_o  (bus_data)
  );

endmodule

// File: rtl/rqw_link_chk.sv
module rqw_link_chk #(
  parameter int DATA_W = 8,
  parameter int TA     = 4,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wait,
  input logic              bus_drive,
  input logic [DATA_W-1:0] bus_data,
  input logic              rd_done,
  input logic [CNT_W-1:0]  rd_cycles,
  input logic              rd_stretched
);

  p_drive_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> bus_req);

  p_idle_bus_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (bus_data == '0));

  p_wait_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> bus_req);

  p_wait_excl_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> !bus_drive);

  p_wait_fall_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_wait) && bus_req) |-> bus_drive);

  p_wait_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wait) |-> $past(bus_req));

  p_done_req_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !bus_req);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  p_fast_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !rd_stretched) |-> (rd_cycles == CNT_W'(TA)));

  p_slow_past_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_stretched) |-> (rd_cycles > CNT_W'(TA)));

endmodule

bind rqw_link rqw_link_chk #(
  .DATA_W (DATA_W),
  .TA     (TA),
  .CNT_W  (CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_wait     (bus_wait),
  .bus_drive    (bus_drive),
  .bus_data     (bus_data),
  .rd_done      (rd_done),
  .rd_cycles    (rd_cycles),
  .rd_stretched (rd_stretched)
);

// File: tb/rqw_link_tb_top.sv
module rqw_link_tb_top;

  localparam int DATA_W = 8;
  localparam int LAT_W  = 4;
  localparam int TA     = 4;
  localparam int CNT_W  = $clog2(15 + 2);

  logic              clk;
  logic              rst_n;
  logic              rd_start;
  logic [LAT_W-1:0]  src_lat;
  logic [DATA_W-1:0] src_val;
  logic              rd_busy;
  logic              rd_done;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  rd_cycles;
  logic              rd_stretched;
  logic              bus_req;
  logic              bus_wait;
  logic              bus_drive;
  logic [DATA_W-1:0] bus_data;

  int checks;
  int errors;
  int cyc_total;
  bit finished;

  rqw_link #(.DATA_W(DATA_W), .LAT_W(LAT_W), .TA(TA)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_start     (rd_start),
    .src_lat      (src_lat),
    .src_val      (src_val),
    .rd_busy      (rd_busy),
    .rd_done      (rd_done),
    .rd_data      (rd_data),
    .rd_cycles    (rd_cycles),
    .rd_stretched (rd_stretched),
    .bus_req      (bus_req),
    .bus_wait     (bus_wait),
    .bus_drive    (bus_drive),
    .bus_data     (bus_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_cycles(int lat);
    return (lat > TA) ? lat : TA;
  endfunction

  function automatic bit exp_wait(int lat, int j);
    return (lat > TA) && (j >= 1) && (j < lat);
  endfunction

  function automatic bit exp_drive(int lat, int j);
    int first;
    first = (lat < 1) ? 1 : lat;
    return (j >= first) && (j <= exp_cycles(lat));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One read: called at a negedge with the link idle, or in a done cycle (R9).
  task automatic do_read(input int lat, input int val, input bit disturb, input bit chain_next);
    int c;
    c = exp_cycles(lat);
    rd_start = 1'b1;
    src_lat  = LAT_W'(lat);
    src_val  = DATA_W'(val);
    @(negedge clk);
    rd_start = 1'b0;
    for (int j = 0; j <= c; j++) begin
      chk(bus_req == 1'b1, (j == 0) ? "R2 req rise" : "R6 req held", int'(bus_req), 1);
      chk(bus_wait == exp_wait(lat, j), (lat > TA) ? "R4 wait" : "R3 wait low",
          int'(bus_wait), int'(exp_wait(lat, j)));
      chk(bus_drive == exp_drive(lat, j), (lat > TA) ? "R4 drive" : "R3 drive",
          int'(bus_drive), int'(exp_drive(lat, j)));
      if (exp_drive(lat, j))
        chk(bus_data == DATA_W'(val), "R8 bus data", int'(bus_data), val);
      chk(rd_done == 1'b0, "R6 done early", int'(rd_done), 0);
      if (disturb && j == 1) begin
        rd_start = 1'b1;
        src_lat  = LAT_W'(lat ^ 5);
        src_val  = DATA_W'(~val);
      end
      if (disturb && j == 2) rd_start = 1'b0;
      @(negedge clk);
    end
    chk(rd_done == 1'b1, "R6 done pulse", int'(rd_done), 1);
    chk(bus_req == 1'b0, "R6 req fall", int'(bus_req), 0);
    chk(rd_data == DATA_W'(val), "R6 data", int'(rd_data), val);
    chk(int'(rd_cycles) == c, (lat > TA) ? "R5 cycles" : "R3 cycles", int'(rd_cycles), c);
    chk(rd_stretched == (lat > TA), "R5 stretched", int'(rd_stretched), int'(lat > TA));
    chk(bus_drive == 1'b0 && bus_data == '0, "R7 bus released", int'(bus_data), 0);
    if (!chain_next) begin
      @(negedge clk);
      chk(bus_req == 1'b0 && rd_done == 1'b0, "R2 no extra read", int'(bus_req), 0);
      @(negedge clk);
      chk(bus_req == 1'b0, "R2 no extra read", int'(bus_req), 0);
    end
  endtask

  initial begin
    cyc_total = 0;
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 100000 && !finished) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 100000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int unused;
    checks   = 0;
    errors   = 0;
    finished = 1'b0;
    rd_start = 1'b0;
    src_lat  = '0;
    src_val  = '0;
    rst_n    = 1'b0;
    unused   = $urandom(32'h1234_5eed);
    repeat (3) @(negedge clk);
    chk(!bus_req && !bus_wait && !bus_drive && !rd_done && bus_data == '0,
        "R1 reset state", int'(bus_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !bus_wait && !bus_drive && !rd_done, "R1 after release", int'(bus_req), 0);

    // Directed corners around the window edge.
    do_read(0, 8'hA5, 1'b0, 1'b0);       // R3 zero latency
    do_read(TA, 8'h3C, 1'b0, 1'b0);      // R3 last fast latency
    do_read(TA + 1, 8'hC3, 1'b0, 1'b0);  // R4 R5 first slow latency
    do_read(15, 8'hFF, 1'b0, 1'b0);      // R5 longest latency
    do_read(2, 8'h00, 1'b1, 1'b0);       // R2 R8 disturbed fast read
    do_read(11, 8'h81, 1'b1, 1'b0);      // R2 R8 disturbed slow read
    do_read(3, 8'h55, 1'b0, 1'b1);       // R9 chained reads
    do_read(9, 8'h66, 1'b0, 1'b1);
    do_read(1, 8'h77, 1'b0, 1'b0);

    // Random reads.
    for (int n = 0; n < 40; n++) begin
      int l;
      int v;
      l = int'($urandom_range(0, 15));
      v = int'($urandom_range(0, 255));
      do_read(l, v, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0));
    end
    @(negedge clk);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule